// File: doc/BRIEF.md
# Parity-Checked Byte Substitution Unit

This unit applies the AES forward byte substitution to one byte per accepted input. It also checks its own result while it runs. A second constant table, addressed by the same input byte, gives the parity that the substituted byte should have. The unit compares that predicted bit with the parity actually present on the output and reports any disagreement. A test-only mask can corrupt the substituted byte before the comparison, so that the detection path can be exercised. The unit only detects errors. The output byte is never repaired.

Every accepted byte produces three results in the following cycle. The first is the output byte. The second is a per-byte error strobe, and the third is a sticky fault flag that software-side logic clears with a pulse. The predicted parity bit of each accepted byte is also queued in a small first-word-fall-through FIFO, so that a downstream checker can read the bits in order. When that FIFO is full, the input is back-pressured.

Top module: `sbox_parity_unit`

## Requirements
- R1: One cycle after a handshake (`in_valid` and `in_ready` both high at a rising edge), `out_valid` is high for exactly one cycle and `out_byte` equals the AES forward substitution of the accepted byte XOR `inj_mask` (for example 0x00 maps to 0x63, 0x53 maps to 0xED, 0xFF maps to 0x16). Without a handshake, `out_valid` is low in the next cycle.
- R2: The predicted parity is the even-parity bit of the correct substituted byte, that is, the XOR of its eight bits. It is read from its own table indexed by the input byte and is not derived from the output byte.
- R3: `out_err` is high only together with `out_valid`, and exactly when the XOR of the eight bits of `out_byte` differs from the predicted bit. An odd-weight `inj_mask` always raises it. An even-weight or zero mask never does.
- R4: No correction is made. A corrupted byte appears on `out_byte` exactly as substitution XOR mask.
- R5: `fault_sticky` rises together with `out_err` and stays high until `clr_fault` is sampled high at an edge where no new error is captured. A new error in the same cycle as a clear leaves the flag set.
- R6: Each handshake pushes the predicted parity bit into the FIFO, and the pushed bit is visible on `fifo_dout` after that edge. `fifo_dout` shows the oldest entry. `fifo_rd` pops one entry when the FIFO is not empty and has no effect when it is empty.
- R7: The FIFO holds 16 bits. `fifo_full` and `fifo_empty` report the occupancy, `in_ready` equals not-full, and a read and a write may occur in the same cycle.
- R8: While `rst_n` is low at a rising edge (a synchronous, active-low reset), the FIFO is emptied, `fault_sticky` is cleared and `out_valid` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Unit can accept a byte (FIFO not full) |
| in_byte | input | 8 | Byte to substitute |
| inj_mask | input | 8 | Test mask XORed into the substituted byte |
| clr_fault | input | 1 | Clears the sticky fault flag |
| out_valid | output | 1 | Output byte valid (one cycle per accepted byte) |
| out_byte | output | 8 | Substituted byte, including any injected corruption |
| out_err | output | 1 | Parity mismatch on the current output byte |
| fault_sticky | output | 1 | Latched fault indication |
| fifo_rd | input | 1 | Pop the oldest parity bit |
| fifo_dout | output | 1 | Oldest predicted parity bit |
| fifo_empty | output | 1 | FIFO holds no entries |
| fifo_full | output | 1 | FIFO holds 16 entries |

## Verification
The hardest state to reach from the ports is a full FIFO that sees a read, a new offer and a fault clear in the same cycle. Reaching it needs sixteen accepted bytes with the read side held idle. The stimulus therefore streams bytes with no reads until `in_ready` falls. It then keeps offering bytes while it pops, so that it can see that the freed slot is taken only on the next edge. The detection path is driven with masks of every weight class. A clear is issued both alone and in the same cycle as a fresh error. All 256 input values are passed through with reads running, so that every parity table entry reaches the FIFO output.

// File: rtl/sbp_pkg.sv
// Package sbp_pkg
// Purpose: constant functions that compute the AES forward substitution at
//          elaboration time, so no table is written out by hand.
// Assumes: the AES field polynomial x^8+x^4+x^3+x+1.
package sbp_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_CODES = 1 << BYTE_W;

    // Multiply two field elements with shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] x;
        acc = 8'h00;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    // Inverse as a^254; zero maps to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] base;
        logic [7:0] e;
        r    = 8'h01;
        base = a;
        e    = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    // Forward substitution: inverse, then the affine map.
    function automatic logic [7:0] sub_fwd(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

endpackage

// File: rtl/sbp_sub_rom.sv
// Module sbp_sub_rom
// Purpose: combinational forward substitution lookup for one byte.
// Assumes: contents are constant and fixed when the design is elaborated.
module sbp_sub_rom (
    input  logic [7:0] addr,
    output logic [7:0] data
);
    logic [7:0] tbl [sbp_pkg::N_CODES];

    // One constant entry per input code.
    for (genvar g = 0; g < sbp_pkg::N_CODES; g++) begin : g_ent
        assign tbl[g] = sbp_pkg::sub_fwd(8'(g));
    end

    // Read port.
    assign data = tbl[addr];
endmodule

// File: rtl/sbp_par_rom.sv
// Module sbp_par_rom
// Purpose: predicted even-parity bit for each substitution result, kept in a
//          separate table addressed by the input byte.
// Assumes: the parity convention is XOR of all eight result bits.
module sbp_par_rom (
    input  logic [7:0] addr,
    output logic       pbit
);
    logic [sbp_pkg::N_CODES-1:0] tbl;

    // One predicted bit per input code.
    for (genvar g = 0; g < sbp_pkg::N_CODES; g++) begin : g_bit
        assign tbl[g] = ^sbp_pkg::sub_fwd(8'(g));
    end

    // Read port.
    assign pbit = tbl[addr];
endmodule

// File: rtl/sbp_fifo.sv
// Module sbp_fifo
// Purpose: first-word-fall-through queue for predicted parity bits.
// Assumes: DEPTH is a power of two; the writer never pushes when full.
module sbp_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && !full;
    assign dout    = mem[rd_ptr];

    // Storage write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R6
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);
endmodule

// File: rtl/sbox_parity_unit.sv
// Module sbox_parity_unit
// Purpose: byte substitution with concurrent parity-prediction fault
//          detection, a sticky fault flag and a queue of predicted bits.
// Assumes: one-stage pipeline, no output back-pressure; a fault is only
//          detected, never corrected; synchronous active-low reset.
module sbox_parity_unit #(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic [7:0] inj_mask,
    input  logic       clr_fault,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_err,
    output logic       fault_sticky,
    input  logic       fifo_rd,
    output logic       fifo_dout,
    output logic       fifo_empty,
    output logic       fifo_full
);
    logic       hs;
    logic [7:0] sub_raw, sub_seen;
    logic       pred_now, err_now;
    logic [7:0] byte_q;
    logic       pred_q, err_q, valid_q, fault_q;

    sbp_sub_rom u_sub (.addr(in_byte), .data(sub_raw));
    sbp_par_rom u_par (.addr(in_byte), .pbit(pred_now));

    assign hs       = in_valid && in_ready;
    assign sub_seen = sub_raw ^ inj_mask;
    assign err_now  = (^sub_seen) ^ pred_now;

    // Output valid stage.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= hs;
    end

    // Capture result, predicted bit and comparison on a handshake.
    always_ff @(posedge clk) begin
        if (hs) begin
            byte_q <= sub_seen;
            pred_q <= pred_now;
            err_q  <= err_now;
        end
    end

    // Sticky fault: a new error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              fault_q <= 1'b0;
        else if (hs && err_now)  fault_q <= 1'b1;
        else if (clr_fault)      fault_q <= 1'b0;
    end

    sbp_fifo #(.DEPTH(FIFO_DEPTH), .W(1)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (hs),
        .din  (pred_now),
        .pop  (fifo_rd),
        .dout (fifo_dout),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    assign in_ready     = !fifo_full;
    assign out_valid    = valid_q;
    assign out_byte     = byte_q;
    assign out_err      = valid_q && err_q;
    assign fault_sticky = fault_q;

    // R1
    valid_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> out_valid);
    // R1
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hs |=> !out_valid);
    // R3
    err_vs_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_err == ((^out_byte) != pred_q)));
    // R5
    err_sets_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> fault_sticky);
    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sticky && !clr_fault) |=> fault_sticky);
    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && fifo_empty && !fault_sticky));
endmodule

// File: tb/tb_sbox_parity_unit.sv
module tb_sbox_parity_unit;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] inj_mask = 8'h00;
    logic       clr_fault = 1'b0;
    logic       fifo_rd = 1'b0;
    logic       in_ready, out_valid, out_err, fault_sticky;
    logic       fifo_dout, fifo_empty, fifo_full;
    logic [7:0] out_byte;

    sbox_parity_unit #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .inj_mask(inj_mask), .clr_fault(clr_fault),
        .out_valid(out_valid), .out_byte(out_byte), .out_err(out_err),
        .fault_sticky(fault_sticky), .fifo_rd(fifo_rd), .fifo_dout(fifo_dout),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference substitution built from log/antilog tables.
    logic [7:0] alog [256];
    int         lg   [256];
    logic [7:0] ref_sub [256];

    // Reference model state.
    bit         mq [$];
    bit         m_valid = 0, m_err = 0, m_fault = 0;
    logic [7:0] m_byte = 8'h00;

    function automatic logic [7:0] xt(input logic [7:0] x);
        return {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    endfunction

    task automatic build_ref();
        alog[0] = 8'h01;
        for (int i = 1; i < 256; i++) alog[i] = alog[i-1] ^ xt(alog[i-1]);
        for (int i = 0; i < 255; i++) lg[alog[i]] = i;
        for (int a = 0; a < 256; a++) begin
            logic [7:0] v, s;
            v = (a == 0) ? 8'h00 : alog[(255 - lg[a]) % 255];
            for (int k = 0; k < 8; k++)
                s[k] = v[k] ^ v[(k+4)%8] ^ v[(k+5)%8] ^ v[(k+6)%8] ^ v[(k+7)%8] ^ ((8'h63 >> k) & 1);
            ref_sub[a] = s;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs with the model at negedge, drive inputs, advance model.
    task automatic cyc(input bit rn, input bit v, input logic [7:0] b,
                       input logic [7:0] m, input bit c, input bit r);
        bit hs, p;
        @(negedge clk);
        chk(in_ready == (mq.size() < DEPTH), "R7 in_ready", in_ready, mq.size() < DEPTH);
        chk(fifo_full == (mq.size() == DEPTH), "R7 fifo_full", fifo_full, mq.size() == DEPTH);
        chk(fifo_empty == (mq.size() == 0), "R6 fifo_empty", fifo_empty, mq.size() == 0);
        if (mq.size() > 0) chk(fifo_dout == mq[0], "R6 fifo_dout", fifo_dout, mq[0]);
        chk(out_valid == m_valid, "R1 out_valid", out_valid, m_valid);
        if (m_valid) chk(out_byte == m_byte, "R1 R4 out_byte", out_byte, m_byte);
        chk(out_err == m_err, "R3 out_err", out_err, m_err);
        chk(fault_sticky == m_fault, "R5 fault_sticky", fault_sticky, m_fault);
        rst_n = rn; in_valid = v; in_byte = b; inj_mask = m; clr_fault = c; fifo_rd = r;
        if (!rn) begin
            mq.delete(); m_valid = 0; m_err = 0; m_fault = 0;
        end else begin
            hs = v && (mq.size() < DEPTH);
            p  = ^ref_sub[b];                       // R2 predicted bit
            if (r && mq.size() > 0) void'(mq.pop_front());
            if (hs) mq.push_back(p);
            m_valid = hs;
            if (hs) m_byte = ref_sub[b] ^ m;
            m_err = hs && ((^(ref_sub[b] ^ m)) != p);
            if (m_err) m_fault = 1;
            else if (c) m_fault = 0;
        end
    endtask

    initial begin
        build_ref();
        repeat (3) @(posedge clk);
        cyc(1, 0, 8'h00, 8'h00, 0, 0);
        // R8 reset state
        @(negedge clk);
        chk(!out_valid && fifo_empty && !fault_sticky && in_ready, "R8 reset state",
            {out_valid, fifo_empty, fault_sticky}, 3'b010);
        // R1 known values, mask zero
        cyc(1, 1, 8'h00, 8'h00, 0, 1);
        cyc(1, 1, 8'h53, 8'h00, 0, 1);
        @(negedge clk);
        chk(out_byte == 8'hED, "R1 0x53 maps to ED", out_byte, 8'hED);
        cyc(1, 1, 8'hFF, 8'h00, 0, 1);
        @(negedge clk);
        chk(out_byte == 8'h16, "R1 0xFF maps to 16", out_byte, 8'h16);
        // R1 R2 R6 all codes, reads running
        for (int i = 0; i < 256; i++) cyc(1, 1, 8'(i), 8'h00, 0, 1);
        for (int i = 0; i < 4; i++) cyc(1, 0, 8'h00, 8'h00, 0, 1);
        // R3 R4 odd-weight masks detected
        cyc(1, 1, 8'h10, 8'h01, 0, 1);
        @(negedge clk);
        chk(out_err && fault_sticky, "R3 odd mask flags", {out_err, fault_sticky}, 2'b11);
        cyc(1, 1, 8'h9A, 8'h07, 0, 1);
        cyc(1, 1, 8'h3C, 8'h80, 0, 1);
        cyc(1, 0, 8'h00, 8'h00, 0, 0);
        cyc(1, 0, 8'h00, 8'h00, 0, 0);     // R5 stays set
        cyc(1, 0, 8'h00, 8'h00, 1, 0);     // R5 clear
        // R3 even-weight masks escape
        cyc(1, 1, 8'h21, 8'h03, 0, 1);
        cyc(1, 1, 8'hC4, 8'hFF, 0, 1);
        @(negedge clk);
        chk(!out_err && !fault_sticky, "R3 even mask escapes", {out_err, fault_sticky}, 2'b00);
        // R5 clear together with a new error: error wins
        cyc(1, 1, 8'h77, 8'h20, 1, 1);
        cyc(1, 0, 8'h00, 8'h00, 0, 1);
        @(negedge clk);
        chk(fault_sticky, "R5 error beats clear", fault_sticky, 1);
        cyc(1, 0, 8'h00, 8'h00, 1, 1);
        // R7 fill without reads, keep offering
        for (int i = 0; i < 20; i++) cyc(1, 1, 8'(i * 13 + 5), 8'h00, 0, 0);
        @(negedge clk);
        chk(fifo_full && !in_ready, "R7 full backpressure", {fifo_full, in_ready}, 2'b10);
        // R7 full with read, offer and clear in one cycle
        for (int i = 0; i < 6; i++) cyc(1, 1, 8'(i + 200), 8'h01, 1, 1);
        // R6 drain past empty
        for (int i = 0; i < 24; i++) cyc(1, 0, 8'h00, 8'h00, 0, 1);
        @(negedge clk);
        chk(fifo_empty, "R6 read on empty ignored", fifo_empty, 1);
        // R8 reset mid-run with state present
        for (int i = 0; i < 5; i++) cyc(1, 1, 8'(i), 8'h01, 0, 0);
        cyc(0, 1, 8'h44, 8'h00, 0, 0);
        cyc(1, 0, 8'h00, 8'h00, 0, 0);
        @(negedge clk);
        chk(fifo_empty && !fault_sticky && !out_valid, "R8 mid-run reset",
            {fifo_empty, fault_sticky, out_valid}, 3'b100);
        cyc(1, 0, 8'h00, 8'h00, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule